// File: doc/BRIEF.md
# Programmable-Format UART Transmitter

This block turns bytes written by a host into an asynchronous serial frame on one output line. A frame is a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit and one or two high stop bits. The bit time is 16 × (divisor + 1) system clocks. The divisor is 12 bits wide and is written as a low byte and a high nibble.

Data moves through two stages: a one-word holding register and a shift register. The host writes a word and watches the holding-empty flag before writing the next one. This flag is the only back-pressure. There is no ready signal, and a write while the holding register is full replaces the word that is waiting. The block has a line-done flag and an interrupt request for each of its two flags. A request is raised only when its own enable bit and the global interrupt input are both high.

Registers are written through a single-cycle write strobe with a 3-bit address. Addresses used: 0 status, 1 control, 2 format, 3 divisor low, 4 divisor high, 5 data.

Top module: `uart_tx_core`

## Requirements
- R1: After reset the block is in this state: `txd` is 1, `udre_flag` is 1, `txc_flag` is 0, both requests are 0, the divisor is 0 and the format is 8 data bits, no parity and 1 stop bit.
- R2: A frame is sent in this order: a 0 start bit, the data bits LSB first, the optional parity bit, then the stop bits at 1. Each bit lasts 16 × (divisor + 1) clocks. The divisor is bits 7:0 written at address 3 together with bits 3:0 written at address 4, which become divisor bits 11:8.
- R3: The character size code is {control bit 2, format bits 2:1}. Codes 0, 1, 2, 3 and 7 select 5, 6, 7, 8 and 9 data bits. The reserved codes 4, 5 and 6 select 8 data bits.
- R4: Format bit 5 set adds a parity bit after the data bits. Format bit 4 set makes that parity odd, and clear makes it even. Parity covers every data bit that is sent, including the ninth.
- R5: Format bit 3 clear gives 1 stop bit. Set, it gives 2 stop bits.
- R6: A write to address 5 while control bit 3 (transmit enable) is set does three things. It loads the holding register with {control bit 0, write data}, where control bit 0 supplies the ninth bit. It drives `udre_flag` to 0 from the next cycle. The word then moves into the shift register, and `udre_flag` returns to 1, on the next edge at which the line is idle or the last stop bit ends.
- R7: A write to address 5 while transmit enable is clear is ignored: `udre_flag` stays 1 and `txd` stays 1.
- R8: `txc_flag` rises on the edge that ends the last stop bit when the holding register is empty. It stays 0 during the frame.
- R9: Writing address 0 with bit 6 set clears `txc_flag`. Writing bit 6 as 0 leaves it unchanged.
- R10: `irq_udre` = `udre_flag` & control bit 5 & `gie`, and `irq_txc` = `txc_flag` & control bit 6 & `gie`.
- R11: `irq_txc_ack` high while `irq_txc` is high clears `txc_flag` on the next edge. With `gie` low no request is raised and both flags keep their values.
- R12: When the holding register is full as the last stop bit ends, the next start bit follows with no idle time between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| gie | input | 1 | Global interrupt enable |
| irq_txc_ack | input | 1 | Host has taken the line-done interrupt |
| txd | output | 1 | Serial line, high when idle |
| udre_flag | output | 1 | Holding register empty |
| txc_flag | output | 1 | Transmission complete |
| irq_udre | output | 1 | Holding-empty interrupt request |
| irq_txc | output | 1 | Line-done interrupt request |

## Verification
The serial line is driven with every character-size code, including a reserved one, and with both parity senses and both stop counts. A data value whose set-bit count differs between the sent bits and the full byte shows whether a truncated or a wrong-sense parity is used. A frame with a nonzero high divisor nibble checks that the divisor bits join correctly. Back-to-back writes separate an idle gap from an immediate restart. Interrupt sequences run with the global enable off and then on, and end with an acknowledge, to check when each flag is set and cleared.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic [2:0] REG_STAT = 3'd0;
  localparam logic [2:0] REG_CTRL = 3'd1;
  localparam logic [2:0] REG_FMT  = 3'd2;
  localparam logic [2:0] REG_DIVL = 3'd3;
  localparam logic [2:0] REG_DIVH = 3'd4;
  localparam logic [2:0] REG_DATA = 3'd5;

  localparam int STAT_TXC   = 6;
  localparam int CTRL_TXCIE = 6;
  localparam int CTRL_UDRIE = 5;
  localparam int CTRL_TXEN  = 3;
  localparam int CTRL_SZ2   = 2;
  localparam int CTRL_D8    = 0;
  localparam int FMT_PEN    = 5;
  localparam int FMT_PODD   = 4;
  localparam int FMT_STOP2  = 3;

  typedef struct packed {
    logic       par_en;
    logic       par_odd;
    logic       stop2;
    logic [2:0] size_code;
  } tx_fmt_t;

  function automatic logic [3:0] size_to_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd5;
      3'd1:    return 4'd6;
      3'd2:    return 4'd7;
      3'd7:    return 4'd9;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             gie,
  input  logic             irq_txc_ack,
  input  logic             load,
  input  logic             txc_set,
  output tx_fmt_t          fmt,
  output logic [DIV_W-1:0] div,
  output logic [8:0]       hold_data,
  output logic             hold_full,
  output logic             udre,
  output logic             txc,
  output logic             irq_udre,
  output logic             irq_txc
);
  localparam int DIVH_W = DIV_W - 8;

  logic [7:0]        div_lo;
  logic [DIVH_W-1:0] div_hi;
  logic              txc_ie, udre_ie, tx_en, sz2, d8;
  logic [1:0]        sz_lo;
  logic              pen, podd, stop2;

  logic wr_stat, wr_data_reg, txc_clr;
  assign wr_stat     = wr_en && (wr_addr == REG_STAT);
  assign wr_data_reg = wr_en && (wr_addr == REG_DATA);
  assign txc_clr     = (irq_txc && irq_txc_ack) || (wr_stat && wr_data[STAT_TXC]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_lo <= '0; div_hi <= '0;
      txc_ie <= 1'b0; udre_ie <= 1'b0; tx_en <= 1'b0; sz2 <= 1'b0; d8 <= 1'b0;
      sz_lo <= 2'b11; pen <= 1'b0; podd <= 1'b0; stop2 <= 1'b0;
      hold_data <= '0; hold_full <= 1'b0; txc <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          REG_CTRL: begin
            txc_ie  <= wr_data[CTRL_TXCIE];
            udre_ie <= wr_data[CTRL_UDRIE];
            tx_en   <= wr_data[CTRL_TXEN];
            sz2     <= wr_data[CTRL_SZ2];
            d8      <= wr_data[CTRL_D8];
          end
          REG_FMT: begin
            pen   <= wr_data[FMT_PEN];
            podd  <= wr_data[FMT_PODD];
            stop2 <= wr_data[FMT_STOP2];
            sz_lo <= wr_data[2:1];
          end
          REG_DIVL: div_lo <= wr_data;
          REG_DIVH: div_hi <= wr_data[DIVH_W-1:0];
          default: ;
        endcase
      end
      if (wr_data_reg && tx_en) begin
        hold_data <= {d8, wr_data};
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      if (txc_set)      txc <= 1'b1;
      else if (txc_clr) txc <= 1'b0;
    end
  end

  assign div      = {div_hi, div_lo};
  assign fmt      = '{par_en: pen, par_odd: podd, stop2: stop2, size_code: {sz2, sz_lo}};
  assign udre     = !hold_full;
  assign irq_udre = udre && udre_ie && gie;
  assign irq_txc  = txc && txc_ie && gie;

  // R6
  udre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_reg && tx_en) |=> !udre);

  // R7
  ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_reg && !tx_en && !hold_full) |=> udre);

  // R11
  txc_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_txc && irq_txc_ack && !txc_set) |=> !txc);
endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 12,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             bit_end
);
  localparam int OVS_W = $clog2(OVS);
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

  logic [DIV_W-1:0] pre;
  logic [OVS_W-1:0] os;
  logic             pre_wrap;

  assign pre_wrap = (pre >= div);
  assign bit_end  = pre_wrap && (os == OVS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      os  <= '0;
    end else if (restart) begin
      pre <= '0;
      os  <= '0;
    end else if (pre_wrap) begin
      pre <= '0;
      os  <= (os == OVS_LAST) ? '0 : os + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R2
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (os == '0));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int FRAME_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_full,
  input  logic [8:0] hold_data,
  input  tx_fmt_t    fmt,
  input  logic       bit_end,
  output logic       load,
  output logic       txc_set,
  output logic       txd
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh, frame;
  logic [CNT_W-1:0]   left, total;
  logic [3:0]         nbits;
  logic               busy, par, last_end;

  always_comb begin
    nbits = size_to_bits(fmt.size_code);
    frame = '1;
    frame[0] = 1'b0;
    par = fmt.par_odd;
    for (int i = 0; i < 9; i++) begin
      if (i < int'(nbits)) begin
        frame[i+1] = hold_data[i];
        par = par ^ hold_data[i];
      end
    end
    if (fmt.par_en) frame[int'(nbits)+1] = par;
    total = CNT_W'(2) + CNT_W'(nbits) + CNT_W'(fmt.par_en) + CNT_W'(fmt.stop2);
  end

  assign last_end = busy && bit_end && (left == CNT_W'(1));
  assign load     = hold_full && (!busy || last_end);
  assign txc_set  = last_end && !hold_full;
  assign txd      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= frame;
      left <= total;
      busy <= 1'b1;
    end else if (busy && bit_end) begin
      sh   <= {1'b1, sh[FRAME_W-1:1]};
      left <= left - 1'b1;
      if (left == CNT_W'(1)) busy <= 1'b0;
    end
  end

  // R8
  txc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txc_set |=> (!busy && txd));

  // R12
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_end && hold_full) |=> (busy && !txd));
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DIV_W   = 12,
  parameter int OVS     = 16,
  parameter int FRAME_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       gie,
  input  logic       irq_txc_ack,
  output logic       txd,
  output logic       udre_flag,
  output logic       txc_flag,
  output logic       irq_udre,
  output logic       irq_txc
);
  tx_fmt_t          fmt;
  logic [DIV_W-1:0] div;
  logic [8:0]       hold_data;
  logic             hold_full, load, txc_set, bit_end;

  uart_tx_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gie(gie), .irq_txc_ack(irq_txc_ack), .load(load), .txc_set(txc_set),
    .fmt(fmt), .div(div), .hold_data(hold_data), .hold_full(hold_full),
    .udre(udre_flag), .txc(txc_flag), .irq_udre(irq_udre), .irq_txc(irq_txc)
  );

  uart_tx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(load), .div(div), .bit_end(bit_end)
  );

  uart_tx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .hold_full(hold_full), .hold_data(hold_data),
    .fmt(fmt), .bit_end(bit_end), .load(load), .txc_set(txc_set), .txd(txd)
  );

  // R10
  irq_udre_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_udre |-> (udre_flag && gie));

  // R11
  irq_gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (!irq_udre && !irq_txc));
endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, wr_en = 1'b0, gie = 1'b0, ack = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  wire        txd, udre, txc, iu, it;

  int checks = 0, errors = 0;

  uart_tx_core u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gie(gie), .irq_txc_ack(ack), .txd(txd), .udre_flag(udre), .txc_flag(txc),
    .irq_udre(iu), .irq_txc(it)
  );

  // reference model state
  bit       m_full, m_busy, m_txc, m_en, m_d8, m_sz2, m_txcie, m_udrie, m_pen, m_podd, m_stop2;
  bit [1:0] m_szlo;
  bit [8:0] m_hold;
  bit       q[$];
  int       m_cnt, m_blen, m_div;

  function automatic int nbits_of(input int code);
    if (code == 7) return 9;
    if (code < 4) return code + 5;
    return 8;
  endfunction

  function automatic bit m_iu();
    return !m_full && m_udrie && gie;
  endfunction

  function automatic bit m_it();
    return m_txc && m_txcie && gie;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit be, last, ld, set, clr;
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_txc = 0; m_en = 0; m_d8 = 0; m_sz2 = 0;
      m_txcie = 0; m_udrie = 0; m_pen = 0; m_podd = 0; m_stop2 = 0;
      m_szlo = 2'b11; m_hold = 0; q.delete(); m_cnt = 0; m_blen = 16; m_div = 0;
    end else begin
      be   = m_busy && (m_cnt == m_blen - 1);
      last = be && (q.size() == 1);
      ld   = m_full && (!m_busy || last);
      set  = last && !m_full;
      clr  = (ack && m_it()) || (wr_en && wr_addr == 3'd0 && wr_data[6]);
      if (m_busy) begin
        if (be) begin void'(q.pop_front()); m_cnt = 0; end
        else m_cnt++;
        if (last) m_busy = 0;
      end
      if (ld) begin
        int n;
        bit p;
        n = nbits_of({m_sz2, m_szlo});
        p = m_podd;
        q.delete();
        q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin q.push_back(m_hold[i]); p ^= m_hold[i]; end
        if (m_pen) q.push_back(p);
        q.push_back(1'b1);
        if (m_stop2) q.push_back(1'b1);
        m_busy = 1; m_cnt = 0; m_blen = 16 * (m_div + 1); m_full = 0;
      end
      if (set) m_txc = 1;
      else if (clr) m_txc = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd1: begin
            m_txcie = wr_data[6]; m_udrie = wr_data[5]; m_en = wr_data[3];
            m_sz2 = wr_data[2]; m_d8 = wr_data[0];
          end
          3'd2: begin
            m_pen = wr_data[5]; m_podd = wr_data[4]; m_stop2 = wr_data[3];
            m_szlo = wr_data[2:1];
          end
          3'd3: m_div = (m_div & 32'hF00) | int'(wr_data);
          3'd4: m_div = (m_div & 32'h0FF) | (int'(wr_data[3:0]) << 8);
          3'd5: if (m_en) begin m_hold = {m_d8, wr_data}; m_full = 1; end
          default: ;
        endcase
      end
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit et;
      et = m_busy ? q[0] : 1'b1;
      chk(txd === et, "R2 R3 R4 R5 R12 txd", int'(txd), int'(et));
      chk(udre === !m_full, "R6 R7 udre_flag", int'(udre), int'(!m_full));
      chk(txc === m_txc, "R8 R9 R11 txc_flag", int'(txc), int'(m_txc));
      chk(iu === m_iu(), "R10 irq_udre", int'(iu), int'(m_iu()));
      chk(it === m_it(), "R10 R11 irq_txc", int'(it), int'(m_it()));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    do @(posedge clk); while (m_busy || m_full);
    repeat (3) @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #5;
    // R1 reset state
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(udre === 1'b1, "R1 udre", int'(udre), 1);
    chk(txc === 1'b0, "R1 txc", int'(txc), 0);
    chk(iu === 1'b0 && it === 1'b0, "R1 irq", int'(iu | it), 0);

    // R7 data write with transmitter disabled
    wr(3'd5, 8'hA5);
    @(posedge clk); #5;
    chk(udre === 1'b1 && txd === 1'b1, "R7 ignored write", int'({udre, txd}), 3);

    // R1 R2 R8 default 8N1, divisor 0: 10 bits x 16 clocks
    wr(3'd1, 8'h08);
    wr(3'd5, 8'h48);
    repeat (160) @(posedge clk);
    #3 chk(txc === 1'b0, "R8 txc before frame end", int'(txc), 0);
    @(posedge clk); #3 chk(txc === 1'b1, "R8 txc at frame end", int'(txc), 1);
    wait_done();

    // R9 write of zero keeps, write of one clears
    wr(3'd0, 8'h00);
    #3 chk(txc === 1'b1, "R9 write zero keeps txc", int'(txc), 1);
    wr(3'd0, 8'h40);
    #3 chk(txc === 1'b0, "R9 write one clears txc", int'(txc), 0);

    // R3 R4 R5 formats over a nonzero divisor
    wr(3'd3, 8'd2);
    wr(3'd2, 8'h00); wr(3'd5, 8'hE7); wait_done();          // 5 bits
    wr(3'd2, 8'h22); wr(3'd5, 8'h2B); wait_done();          // 6 bits even parity
    wr(3'd2, 8'h3C); wr(3'd5, 8'h81); wait_done();          // 7 bits odd, 2 stop
    wr(3'd1, 8'h0D); wr(3'd2, 8'h36); wr(3'd5, 8'h03); wait_done(); // 9 bits odd
    wr(3'd1, 8'h0C); wr(3'd2, 8'h22); wr(3'd5, 8'h5A); wait_done(); // reserved code 5
    wr(3'd1, 8'h08); wr(3'd2, 8'h06);

    // R12 back-to-back frames
    wr(3'd5, 8'h11);
    wr(3'd5, 8'hEE);
    #3 chk(udre === 1'b0, "R6 holding full", int'(udre), 0);
    wait_done();

    // R10 R11 interrupts
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h68);
    #3 chk(iu === 1'b0, "R11 no request with gie low", int'(iu), 0);
    wr(3'd5, 8'h33); wait_done();
    chk(it === 1'b0 && txc === 1'b1 && udre === 1'b1, "R11 flags kept with gie low",
        int'({it, txc, udre}), 3);
    @(posedge clk); #2 gie = 1'b1;
    @(posedge clk); #3;
    chk(iu === 1'b1 && it === 1'b1, "R10 requests with gie high", int'({iu, it}), 3);
    @(posedge clk); #2 ack = 1'b1;
    @(posedge clk); #2 ack = 1'b0;
    #3 chk(txc === 1'b0 && it === 1'b0, "R11 ack clears txc", int'({txc, it}), 0);

    // R2 divisor high nibble: 0x101, 5 bits no parity
    wr(3'd1, 8'h08); gie = 1'b0;
    wr(3'd3, 8'h01); wr(3'd4, 8'hF1); wr(3'd2, 8'h00);
    wr(3'd5, 8'h15); wait_done();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule